// File: doc/BRIEF.md
# Serpentine Search-Window Register Array

This block holds a square window of reference pixels and moves it across a full-search area so that two matching engines can each compare one candidate block per cycle. For a current block of N×N pixels the window is N+1 rows by N+1 columns. Rows 0..N-1 form the first candidate and rows 1..N form the second, one pixel row lower. The extra column on the right is kept filled so that the move to the next search column needs only one new column of pixels.

A start pulse begins a search. The window is first filled column by column. It then walks down search column 0 two rows at a time, steps one pixel to the right, walks up column 1, and so on in serpentine order until all 2·RANGE columns are covered. Each step fetches from the search-area memory either two new full-width rows or one new full-height column. The memory answers in the same cycle. The whole window is presented every cycle, with a valid strobe and the displacement of the first candidate. The SAD arithmetic and the motion-vector choice belong to the engines downstream.

Top module: `srch_win_shifter`

## Requirements
- R1: After reset, cand_valid_o, scan_done_o and busy_o are 0 and fetch_kind_o is 0 (no fetch).
- R2: A start_i pulse sampled while idle is followed by N+1 fill cycles, with fetch_kind_o=1 and fetch_y_o=-RANGE. In fill cycle k, fetch_x_o is -RANGE+k. cand_valid_o first rises in the cycle right after the last fill cycle.
- R3: While cand_valid_o is 1, window cell (r,c) equals reference pixel (cand_dy_o+r, cand_dx_o+c) for every r,c in 0..N. Cell (r,c) is win_o bits [(r*(N+1)+c)*PIX_W +: PIX_W]. The second candidate is therefore at vertical displacement cand_dy_o+1.
- R4: Each search column gives exactly RANGE consecutive valid cycles. Even-numbered columns (counting from 0) start at cand_dy_o=-RANGE and step by +2. Odd-numbered columns start at RANGE-2 and step by -2. cand_dx_o holds at -RANGE+column throughout the column.
- R5: Between two search columns there is exactly one cycle with cand_valid_o=0. After it, cand_dx_o has grown by 1.
- R6: After the last candidate of column 2·RANGE-1, scan_done_o is 1 for exactly one cycle, and then busy_o is 0.
- R7: Fetch encoding on fetch_kind_o: 0 none, 1 column, 2 row pair. For a column fetch, col_data_i element i is the pixel at (fetch_y_o+i, fetch_x_o). For a row-pair fetch, rows_data_i element k*(N+1)+c is the pixel at (fetch_y_o+k, fetch_x_o+c). Data must be valid in the same cycle.
- R8: start_i has no effect while busy_o is 1, so the scan order and the window contents stay unchanged.
- R9: Every pixel any fetch asks for lies within rows and columns -RANGE .. RANGE+N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a search when idle |
| fetch_kind_o | output | 2 | Fetch request type (R7 encoding) |
| fetch_y_o | output | CW | Signed first row of the fetch |
| fetch_x_o | output | CW | Signed first column of the fetch |
| col_data_i | input | (N+1)*PIX_W | Column fetch data, element i at bits i*PIX_W |
| rows_data_i | input | 2*(N+1)*PIX_W | Row-pair fetch data |
| win_o | output | (N+1)*(N+1)*PIX_W | Full window contents, row-major |
| cand_valid_o | output | 1 | Window holds a candidate pair |
| cand_dy_o | output | CW | Signed vertical displacement of the first candidate |
| cand_dx_o | output | CW | Signed horizontal displacement of both candidates |
| scan_done_o | output | 1 | One-cycle pulse after the last candidate pair |
| busy_o | output | 1 | A search is in progress |

## Verification
The assertions assume the memory returns the pixels of the requested coordinates in the same cycle. The row-reuse properties only check that stored pixels moved correctly, and the window checks rely on this same-cycle answer. The bench keeps to it with a combinational frame model that is indexed by the fetch outputs. Its start pulses arrive either while idle or in the middle of a scan, and never in the done cycle. A small block and range (N=4, RANGE=3) let the bench compare every window cell against the frame at each candidate.

// File: rtl/srch_win_pkg.sv
package srch_win_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LEFT = 2'd1,
        OP_DOWN = 2'd2,
        OP_UP   = 2'd3
    } shift_op_e;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_COL  = 2'd1,
        FK_ROWS = 2'd2
    } fetch_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_FILL  = 3'd1,
        PH_SCAN  = 3'd2,
        PH_SHIFT = 3'd3,
        PH_DONE  = 3'd4
    } phase_e;

endpackage

// File: rtl/srch_win_ctrl.sv
module srch_win_ctrl
    import srch_win_pkg::*;
#(
    parameter int N     = 32,
    parameter int RANGE = 24,
    parameter int CW    = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    output shift_op_e            op_o,
    output fetch_kind_e          fetch_kind_o,
    output logic signed [CW-1:0] fetch_y_o,
    output logic signed [CW-1:0] fetch_x_o,
    output logic                 cand_valid_o,
    output logic signed [CW-1:0] cand_dy_o,
    output logic signed [CW-1:0] cand_dx_o,
    output logic                 scan_done_o,
    output logic                 busy_o
);

    localparam int SW    = $clog2(RANGE) + 1;
    localparam int KW    = $clog2(2 * RANGE) + 1;
    localparam int LW    = $clog2(N + 1) + 1;
    localparam int RN    = -RANGE;
    localparam int LIMHI = RANGE + N - 1;
    localparam logic signed [CW-1:0] ORIGIN = CW'(RN);

    typedef struct packed {
        phase_e          phase;
        logic            dir_up;
        logic [CW-1:0]   ybase;
        logic [CW-1:0]   xbase;
        logic [SW-1:0]   step;
        logic [KW-1:0]   col;
        logic [LW-1:0]   fill;
    } ctrl_s;

    ctrl_s st_d, st_q;

    always_comb begin
        st_d         = st_q;
        op_o         = OP_HOLD;
        fetch_kind_o = FK_NONE;
        fetch_y_o    = '0;
        fetch_x_o    = '0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_FILL;
                    st_d.fill  = '0;
                end
            end
            PH_FILL: begin
                op_o         = OP_LEFT;
                fetch_kind_o = FK_COL;
                fetch_y_o    = ORIGIN;
                fetch_x_o    = ORIGIN + $signed(CW'(st_q.fill));
                if (st_q.fill == LW'(N)) begin
                    st_d.phase  = PH_SCAN;
                    st_d.ybase  = ORIGIN;
                    st_d.xbase  = ORIGIN;
                    st_d.dir_up = 1'b0;
                    st_d.step   = '0;
                    st_d.col    = '0;
                end else begin
                    st_d.fill = st_q.fill + 1'b1;
                end
            end
            PH_SCAN: begin
                if (st_q.step != SW'(RANGE - 1)) begin
                    fetch_kind_o = FK_ROWS;
                    fetch_x_o    = st_q.xbase;
                    st_d.step    = st_q.step + 1'b1;
                    if (st_q.dir_up) begin
                        op_o       = OP_UP;
                        fetch_y_o  = st_q.ybase - CW'(2);
                        st_d.ybase = st_q.ybase - CW'(2);
                    end else begin
                        op_o       = OP_DOWN;
                        fetch_y_o  = st_q.ybase + CW'(N + 1);
                        st_d.ybase = st_q.ybase + CW'(2);
                    end
                end else if (st_q.col == KW'(2 * RANGE - 1)) begin
                    st_d.phase = PH_DONE;
                end else begin
                    st_d.phase = PH_SHIFT;
                end
            end
            PH_SHIFT: begin
                op_o         = OP_LEFT;
                fetch_kind_o = FK_COL;
                fetch_y_o    = st_q.ybase;
                fetch_x_o    = st_q.xbase + CW'(N + 1);
                st_d.xbase   = st_q.xbase + CW'(1);
                st_d.col     = st_q.col + 1'b1;
                st_d.dir_up  = ~st_q.dir_up;
                st_d.step    = '0;
                st_d.phase   = PH_SCAN;
            end
            PH_DONE: begin
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, dir_up: 1'b0, ybase: '0, xbase: '0,
                      step: '0, col: '0, fill: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cand_valid_o = (st_q.phase == PH_SCAN);
    assign cand_dy_o    = st_q.ybase;
    assign cand_dx_o    = st_q.xbase;
    assign scan_done_o  = (st_q.phase == PH_DONE);
    assign busy_o       = (st_q.phase != PH_IDLE);

    // R4: downward columns advance two rows per candidate step
    a_r4_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_SCAN && !st_q.dir_up && st_q.step != SW'(RANGE - 1))
        |=> (cand_valid_o && cand_dy_o == $past(cand_dy_o) + CW'(2)));

    // R4: upward columns retreat two rows per candidate step
    a_r4_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_SCAN && st_q.dir_up && st_q.step != SW'(RANGE - 1))
        |=> (cand_valid_o && cand_dy_o == $past(cand_dy_o) - CW'(2)));

    // R4: reported displacement stays inside the vertical range
    a_r4_dy_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cand_valid_o |-> ($signed(cand_dy_o) >= RN && $signed(cand_dy_o) <= RANGE - 2));

    // R5: a lateral cycle is followed by a candidate one column right
    a_r5_one_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !cand_valid_o && $past(cand_valid_o) && !scan_done_o)
        |=> (cand_valid_o && cand_dx_o == $past(cand_dx_o) + CW'(1)));

    // R6: done is a single pulse that returns the block to idle
    a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scan_done_o |=> (!scan_done_o && !busy_o));

    // R9: every fetch stays inside the search area
    a_r9_fetch_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fetch_kind_o != FK_NONE) |->
        ($signed(fetch_y_o) >= RN && $signed(fetch_x_o) >= RN &&
         $signed(fetch_y_o) + ((fetch_kind_o == FK_COL) ? N : 1) <= LIMHI &&
         $signed(fetch_x_o) + ((fetch_kind_o == FK_COL) ? 0 : N) <= LIMHI));

endmodule

// File: rtl/srch_win_array.sv
module srch_win_array
    import srch_win_pkg::*;
#(
    parameter int N     = 32,
    parameter int PIX_W = 8
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  shift_op_e                      op_i,
    input  logic [(N+1)*PIX_W-1:0]         col_data_i,
    input  logic [2*(N+1)*PIX_W-1:0]       rows_data_i,
    output logic [(N+1)*(N+1)*PIX_W-1:0]   win_o
);

    localparam int SIDE = N + 1;

    logic [PIX_W-1:0] col_pix [SIDE];
    logic [PIX_W-1:0] row_pix [2][SIDE];
    logic [PIX_W-1:0] cell_d  [SIDE][SIDE];
    logic [PIX_W-1:0] cell_q  [SIDE][SIDE];

    for (genvar gr = 0; gr < SIDE; gr++) begin : g_unpack_r
        assign col_pix[gr]    = col_data_i[gr*PIX_W +: PIX_W];
        assign row_pix[0][gr] = rows_data_i[gr*PIX_W +: PIX_W];
        assign row_pix[1][gr] = rows_data_i[(SIDE+gr)*PIX_W +: PIX_W];
        for (genvar gc = 0; gc < SIDE; gc++) begin : g_pack_c
            assign win_o[(gr*SIDE+gc)*PIX_W +: PIX_W] = cell_q[gr][gc];
        end
    end

    always_comb begin
        for (int r = 0; r < SIDE; r++) begin
            for (int c = 0; c < SIDE; c++) begin
                case (op_i)
                    OP_LEFT:
                        cell_d[r][c] = (c == N) ? col_pix[r]
                                                : cell_q[r][(c < N) ? c + 1 : c];
                    OP_DOWN:
                        cell_d[r][c] = (r >= N - 1)
                            ? row_pix[(r >= N - 1) ? r - (N - 1) : 0][c]
                            : cell_q[(r < N - 1) ? r + 2 : r][c];
                    OP_UP:
                        cell_d[r][c] = (r < 2)
                            ? row_pix[(r < 2) ? r : 0][c]
                            : cell_q[(r >= 2) ? r - 2 : r][c];
                    default:
                        cell_d[r][c] = cell_q[r][c];
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        for (int r = 0; r < SIDE; r++) begin
            for (int c = 0; c < SIDE; c++) begin
                if (!rst_ni) cell_q[r][c] <= '0;
                else         cell_q[r][c] <= cell_d[r][c];
            end
        end
    end

    // R3: a downward step keeps the old lower rows, moved up by two
    a_r3_down_reuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_DOWN) |=> (cell_q[0][0] == $past(cell_q[2][0])));

    // R3: an upward step keeps the old upper rows, moved down by two
    a_r3_up_reuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_UP) |=> (cell_q[N][N] == $past(cell_q[N-2][N])));

    // R3: a lateral move shifts every column left by one
    a_r3_left_reuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_LEFT) |=> (cell_q[N][0] == $past(cell_q[N][1])));

    // R5: the window is frozen while the controller holds it
    a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_HOLD) |=> $stable(cell_q[N][N]));

endmodule

// File: rtl/srch_win_shifter.sv
module srch_win_shifter
    import srch_win_pkg::*;
#(
    parameter int N     = 32,
    parameter int RANGE = 24,
    parameter int PIX_W = 8,
    parameter int CW    = $clog2(RANGE + N + 2) + 2
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          start_i,
    output logic [1:0]                    fetch_kind_o,
    output logic signed [CW-1:0]          fetch_y_o,
    output logic signed [CW-1:0]          fetch_x_o,
    input  logic [(N+1)*PIX_W-1:0]        col_data_i,
    input  logic [2*(N+1)*PIX_W-1:0]      rows_data_i,
    output logic [(N+1)*(N+1)*PIX_W-1:0]  win_o,
    output logic                          cand_valid_o,
    output logic signed [CW-1:0]          cand_dy_o,
    output logic signed [CW-1:0]          cand_dx_o,
    output logic                          scan_done_o,
    output logic                          busy_o
);

    shift_op_e   op;
    fetch_kind_e kind;

    srch_win_ctrl #(.N(N), .RANGE(RANGE), .CW(CW)) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .op_o         (op),
        .fetch_kind_o (kind),
        .fetch_y_o    (fetch_y_o),
        .fetch_x_o    (fetch_x_o),
        .cand_valid_o (cand_valid_o),
        .cand_dy_o    (cand_dy_o),
        .cand_dx_o    (cand_dx_o),
        .scan_done_o  (scan_done_o),
        .busy_o       (busy_o)
    );

    srch_win_array #(.N(N), .PIX_W(PIX_W)) u_array (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .op_i        (op),
        .col_data_i  (col_data_i),
        .rows_data_i (rows_data_i),
        .win_o       (win_o)
    );

    assign fetch_kind_o = kind;

endmodule

// File: tb/srch_win_shifter_test.sv
module srch_win_shifter_test;

    localparam int N     = 4;
    localparam int RANGE = 3;
    localparam int PIX_W = 8;
    localparam int CW    = $clog2(RANGE + N + 2) + 2;
    localparam int SIDE  = N + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] fetch_kind;
    logic signed [CW-1:0] fetch_y, fetch_x, cand_dy, cand_dx;
    logic [SIDE*PIX_W-1:0] col_data;
    logic [2*SIDE*PIX_W-1:0] rows_data;
    logic [SIDE*SIDE*PIX_W-1:0] win;
    logic cand_valid, scan_done, busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    srch_win_shifter #(.N(N), .RANGE(RANGE), .PIX_W(PIX_W), .CW(CW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .fetch_kind_o(fetch_kind), .fetch_y_o(fetch_y), .fetch_x_o(fetch_x),
        .col_data_i(col_data), .rows_data_i(rows_data), .win_o(win),
        .cand_valid_o(cand_valid), .cand_dy_o(cand_dy), .cand_dx_o(cand_dx),
        .scan_done_o(scan_done), .busy_o(busy)
    );

    function automatic logic [PIX_W-1:0] pix(int y, int x);
        int a = y + 50;
        int b = x + 50;
        return PIX_W'(a * 29 + b * 13 + a * b);
    endfunction

    // Reference frame memory, answering in the same cycle (R7)
    always_comb begin
        for (int i = 0; i < SIDE; i++) begin
            col_data[i*PIX_W +: PIX_W]          = pix(int'(fetch_y) + i, int'(fetch_x));
            rows_data[i*PIX_W +: PIX_W]         = pix(int'(fetch_y), int'(fetch_x) + i);
            rows_data[(SIDE+i)*PIX_W +: PIX_W]  = pix(int'(fetch_y) + 1, int'(fetch_x) + i);
        end
    end

    task automatic check(string req, logic ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_window(string req);
        int bad = 0;
        int act = 0;
        int exp = 0;
        for (int r = 0; r < SIDE; r++) begin
            for (int c = 0; c < SIDE; c++) begin
                if (bad == 0 && win[(r*SIDE+c)*PIX_W +: PIX_W] !== pix(int'(cand_dy) + r, int'(cand_dx) + c)) begin
                    bad = 1;
                    act = int'(win[(r*SIDE+c)*PIX_W +: PIX_W]);
                    exp = int'(pix(int'(cand_dy) + r, int'(cand_dx) + c));
                end
            end
        end
        check(req, bad == 0, act, exp);
    endtask

    task automatic check_bounds();
        int ylast;
        int xlast;
        if (fetch_kind != 2'd0) begin
            ylast = int'(fetch_y) + ((fetch_kind == 2'd1) ? N : 1);
            xlast = int'(fetch_x) + ((fetch_kind == 2'd1) ? 0 : N);
            // R9: fetch inside the search area
            check("R9 fetch row low", int'(fetch_y) >= -RANGE, int'(fetch_y), -RANGE);
            check("R9 fetch row high", ylast <= RANGE + N - 1, ylast, RANGE + N - 1);
            check("R9 fetch col low", int'(fetch_x) >= -RANGE, int'(fetch_x), -RANGE);
            check("R9 fetch col high", xlast <= RANGE + N - 1, xlast, RANGE + N - 1);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check("R1 valid", cand_valid == 1'b0, int'(cand_valid), 0);
        check("R1 done", scan_done == 1'b0, int'(scan_done), 0);
        check("R1 busy", busy == 1'b0, int'(busy), 0);
        check("R1 fetch", fetch_kind == 2'd0, int'(fetch_kind), 0);
    endtask

    // One full scan; poke >= 0 raises start at that candidate index (R8)
    task automatic t_scan(int poke);
        int idx = 0;
        int exp_dy;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: fill phase, one column per cycle
        for (int k = 0; k < SIDE; k++) begin
            check("R2 fill kind", fetch_kind == 2'd1, int'(fetch_kind), 1);
            check("R2 fill col", int'(fetch_x) == -RANGE + k, int'(fetch_x), -RANGE + k);
            check("R2 fill row", int'(fetch_y) == -RANGE, int'(fetch_y), -RANGE);
            check("R2 no early valid", cand_valid == 1'b0, int'(cand_valid), 0);
            check_bounds();
            @(negedge clk);
        end
        for (int col = 0; col < 2 * RANGE; col++) begin
            for (int s = 0; s < RANGE; s++) begin
                exp_dy = (col % 2 == 0) ? (-RANGE + 2 * s) : (RANGE - 2 - 2 * s);
                check((poke >= 0) ? "R8 valid" : "R4 valid", cand_valid == 1'b1, int'(cand_valid), 1);
                check("R4 dy order", int'(cand_dy) == exp_dy, int'(cand_dy), exp_dy);
                check("R4 dx hold", int'(cand_dx) == -RANGE + col, int'(cand_dx), -RANGE + col);
                check_window((poke >= 0) ? "R8 window" : "R3 window");
                check_bounds();
                if (idx == poke) start = 1'b1;
                idx++;
                @(negedge clk);
                start = 1'b0;
            end
            if (col < 2 * RANGE - 1) begin
                // R5: single lateral cycle with a column fetch
                check("R5 gap", cand_valid == 1'b0, int'(cand_valid), 0);
                check("R5 shift col", int'(fetch_x) == -RANGE + col + SIDE,
                      int'(fetch_x), -RANGE + col + SIDE);
                check_bounds();
                @(negedge clk);
            end
        end
        // R6: done pulse, then idle
        check("R6 done", scan_done == 1'b1, int'(scan_done), 1);
        check("R6 no valid", cand_valid == 1'b0, int'(cand_valid), 0);
        @(negedge clk);
        check("R6 done low", scan_done == 1'b0, int'(scan_done), 0);
        check("R6 idle", busy == 1'b0, int'(busy), 0);
        check((poke >= 0) ? "R8 idle fetch" : "R7 idle fetch", fetch_kind == 2'd0, int'(fetch_kind), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_scan(-1);
        repeat (2) @(negedge clk);
        t_scan(RANGE + 1);
        t_scan(0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule